// File: doc/BRIEF.md
# Two-Segment Multilevel Voltage Sequencer

This block turns a continuous ac-side voltage demand into a stepped output for a stack of identical full-bridge cells. At the start of each fixed sampling period it samples three inputs: a signed fixed-point voltage demand, the mean cell dc-link voltage (one level step), and a first-segment duration counted in system clock cycles. It then finds the two neighbouring output levels on either side of the demand. It drives the lower level first and switches to the upper level once the supplied duration has elapsed. The second segment fills the rest of the period.

With the default of three cells there are seven levels, from −3 to +3 steps. A demand at or above +3 steps, or below −3 steps, cannot be bracketed by two neighbours. In that case the block holds the nearest extreme level for the whole period. An upstream predictive controller computes the demand and the split instant. A per-cell modulator turns the signed level index into gate patterns.

Top module: `mlvl_seq`

## Requirements
- R1: From reset until the first period strobe, `level_out` is 0 and `seg_upper` is 0.
- R2: When −3·avg ≤ demand < 3·avg, the lower level is the largest integer k with k·avg ≤ demand, and the upper level is k+1. A demand that equals a level exactly selects that level as the lower one. `level_out` is a 3-bit two's-complement index.
- R3: Count the cycles after the strobe edge from 0. In cycles 0 to t−1 the output is the lower level and `seg_upper` is 0. From cycle t on, the output is the upper level and `seg_upper` is 1.
- R4: A demand ≥ 3·avg gives level +3 for the whole period.
- R5: A demand < −3·avg gives level −3 for the whole period.
- R6: A negative duration is treated as 0, which puts the whole period at the upper level. A duration larger than the period is treated as the period, which puts the whole period at the lower level.
- R7: Inputs are sampled only on the strobe. Changing them between strobes does not change the output.
- R8: A strobe arriving before the period ends restarts timing from cycle 0 with the newly sampled inputs.
- R9: Within a period, the level changes by at most one step from one cycle to the next.
- R10: After the last cycle of the period, the output holds its final value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_start | input | 1 | One-cycle strobe that begins a sampling period |
| v_demand | input | DATA_W | Signed desired total ac-side voltage |
| v_cell_avg | input | DATA_W | Unsigned mean cell dc-link voltage (one level step) |
| t_first | input | DUR_W | Signed first-segment duration in clock cycles |
| level_out | output | LVL_W | Signed level index applied now |
| seg_upper | output | 1 | High while the second segment is active |

## Verification
The bench builds the block with PERIOD_CYC = 20 and DATA_W = 12 and keeps three cells. Twenty-cycle periods let every sampled cycle of a period be compared, including the hold after its end. They also make durations past the period cheap to reach. A level step of 100 exercises exact level boundaries at both ends of the range, one-count-below-threshold demands, and saturation on both sides. A strobe is also issued mid-period to restart timing.

// File: rtl/mlvl_pkg.sv
// Shared types for the multilevel sequencer.
// Assumes nothing beyond a single clock domain.
package mlvl_pkg;
    typedef enum logic {
        SEG_FIRST  = 1'b0,
        SEG_SECOND = 1'b1
    } seg_e;
endpackage

// File: rtl/mlvl_lvl_pick.sv
// Picks the two adjacent levels that bracket the demand.
// Compares the demand against every level threshold j*avg, for j from -N to +N.
// Assumes avg >= 0 and that products fit in DATA_W+LVL_W+1 bits.
// Saturates to +-N when no bracketing pair exists.
module mlvl_lvl_pick #(
    parameter int DATA_W  = 16,
    parameter int N_CELLS = 3,
    parameter int LVL_W   = 3
) (
    input  logic signed [DATA_W-1:0] dem,
    input  logic        [DATA_W-1:0] avg,
    output logic signed [LVL_W-1:0]  lo_lvl,
    output logic signed [LVL_W-1:0]  hi_lvl
);
    localparam int NT = 2 * N_CELLS + 1;
    localparam int PW = DATA_W + LVL_W + 1;

    logic signed [PW-1:0] dem_x;
    logic signed [PW-1:0] avg_x;
    logic [NT-1:0]        ge;
    int                   nge;

    assign dem_x = PW'(dem);
    assign avg_x = PW'($signed({1'b0, avg}));

    // one comparator per level threshold
    for (genvar g = 0; g < NT; g++) begin : g_thr
        localparam int J = g - N_CELLS;
        logic signed [PW-1:0] thr;
        assign thr   = avg_x * PW'(J);
        assign ge[g] = (dem_x >= thr);
    end

    // map the number of passed thresholds onto a level pair
    always_comb begin
        nge = $countones(ge);
        if (nge == 0) begin
            lo_lvl = LVL_W'(-N_CELLS);
            hi_lvl = LVL_W'(-N_CELLS);
        end else if (nge == NT) begin
            lo_lvl = LVL_W'(N_CELLS);
            hi_lvl = LVL_W'(N_CELLS);
        end else begin
            lo_lvl = LVL_W'(nge - N_CELLS - 1);
            hi_lvl = LVL_W'(nge - N_CELLS);
        end
    end
endmodule

// File: rtl/mlvl_dur_clamp.sv
// Clamps the signed first-segment duration into the range 0 to PERIOD_CYC.
// Assumes DUR_W is wide enough to hold PERIOD_CYC as a positive value.
module mlvl_dur_clamp #(
    parameter int PERIOD_CYC = 50000,
    parameter int DUR_W      = 18,
    parameter int TW         = 17
) (
    input  logic signed [DUR_W-1:0] t_in,
    output logic        [TW-1:0]    t_out
);
    localparam logic signed [DUR_W-1:0] PMAX = DUR_W'(PERIOD_CYC);

    // saturate below at zero and above at the period
    always_comb begin
        if (t_in < 0)
            t_out = '0;
        else if (t_in > PMAX)
            t_out = TW'(PERIOD_CYC);
        else
            t_out = TW'(t_in);
    end
endmodule

// File: rtl/mlvl_seg_timer.sv
// Latches the level pair and the split instant on the strobe.
// Counts the cycles of the period and drives the lower level first, then the upper.
// The counter stops at the last cycle of the period, so the output holds until the next strobe.
module mlvl_seg_timer
    import mlvl_pkg::*;
#(
    parameter int PERIOD_CYC = 50000,
    parameter int LVL_W      = 3,
    parameter int TW         = 17
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [LVL_W-1:0] lo_in,
    input  logic signed [LVL_W-1:0] hi_in,
    input  logic        [TW-1:0]    t1_in,
    output logic signed [LVL_W-1:0] level_out,
    output logic                    seg_upper
);
    localparam int CNT_W = TW - 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

    logic                    active;
    logic [CNT_W-1:0]        cnt;
    logic signed [LVL_W-1:0] lo_q, hi_q;
    logic [TW-1:0]           t1_q;
    seg_e                    seg_now;

    // latch on the strobe, then advance the counter until the last cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            t1_q   <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            lo_q   <= lo_in;
            hi_q   <= hi_in;
            t1_q   <= t1_in;
        end else if (active && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // select the segment from the counter position
    always_comb begin
        seg_now   = ({1'b0, cnt} < t1_q) ? SEG_FIRST : SEG_SECOND;
        seg_upper = active && (seg_now == SEG_SECOND);
        if (!active)
            level_out = '0;
        else
            level_out = (seg_now == SEG_FIRST) ? lo_q : hi_q;
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (level_out == '0 && !seg_upper)); // R1
    AST_SEG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_upper && !start) |=> seg_upper); // R3
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start) |=>
        ((int'(level_out) - int'($past(level_out)) <= 1) &&
         (int'($past(level_out)) - int'(level_out) <= 1))); // R9
    AST_HOLD_END: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt == LAST && !start) |=> $stable(level_out)); // R10
endmodule

// File: rtl/mlvl_seq.sv
// Top level of the two-segment multilevel voltage sequencer.
// Selects the bracketing level pair and clamps the split instant from the inputs.
// The timer registers both on the period strobe.
// Assumes a synchronous active-low reset, and DUR_W > $clog2(PERIOD_CYC)+1.
module mlvl_seq #(
    parameter int DATA_W     = 16,
    parameter int N_CELLS    = 3,
    parameter int PERIOD_CYC = 50000,
    parameter int DUR_W      = 18,
    parameter int LVL_W      = $clog2(N_CELLS + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     period_start,
    input  logic signed [DATA_W-1:0] v_demand,
    input  logic        [DATA_W-1:0] v_cell_avg,
    input  logic signed [DUR_W-1:0]  t_first,
    output logic signed [LVL_W-1:0]  level_out,
    output logic                     seg_upper
);
    localparam int TW = $clog2(PERIOD_CYC) + 1;

    logic signed [LVL_W-1:0] lo_lvl, hi_lvl;
    logic        [TW-1:0]    t1_c;

    mlvl_lvl_pick #(.DATA_W(DATA_W), .N_CELLS(N_CELLS), .LVL_W(LVL_W)) u_pick (
        .dem    (v_demand),
        .avg    (v_cell_avg),
        .lo_lvl (lo_lvl),
        .hi_lvl (hi_lvl)
    );

    mlvl_dur_clamp #(.PERIOD_CYC(PERIOD_CYC), .DUR_W(DUR_W), .TW(TW)) u_clamp (
        .t_in  (t_first),
        .t_out (t1_c)
    );

    mlvl_seg_timer #(.PERIOD_CYC(PERIOD_CYC), .LVL_W(LVL_W), .TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (period_start),
        .lo_in     (lo_lvl),
        .hi_in     (hi_lvl),
        .t1_in     (t1_c),
        .level_out (level_out),
        .seg_upper (seg_upper)
    );

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(level_out) >= -N_CELLS) && (int'(level_out) <= N_CELLS)); // R2
endmodule

// File: tb/mlvl_seq_tb.sv
`timescale 1ns/1ps
module mlvl_seq_tb;
    localparam int DW = 12;
    localparam int P  = 20;
    localparam int DUR_W = 18;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    period_start = 1'b0;
    logic signed [DW-1:0]    v_demand = '0;
    logic        [DW-1:0]    v_cell_avg = '0;
    logic signed [DUR_W-1:0] t_first = '0;
    logic signed [2:0]       level_out;
    logic                    seg_upper;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mlvl_seq #(.DATA_W(DW), .N_CELLS(3), .PERIOD_CYC(P), .DUR_W(DUR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .period_start(period_start),
        .v_demand(v_demand), .v_cell_avg(v_cell_avg), .t_first(t_first),
        .level_out(level_out), .seg_upper(seg_upper)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Start a period, scramble the inputs afterwards, and check nsamp cycles.
    task automatic run_period(input int dem, input int avg, input int t1,
                              input int lo, input int hi, input int nsamp,
                              input string req);
        int t1c;
        @(negedge clk);
        v_demand = DW'(dem); v_cell_avg = DW'(avg); t_first = DUR_W'(t1);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        v_demand = DW'(-dem - 37); t_first = DUR_W'(t1 + 5); // R7: must be ignored
        t1c = (t1 < 0) ? 0 : ((t1 > P) ? P : t1);
        for (int k = 0; k < nsamp; k++) begin
            int keff;
            int exp_lvl;
            if (k > 0) @(negedge clk);
            keff = (k > P - 1) ? P - 1 : k;
            exp_lvl = (keff < t1c) ? lo : hi;
            chk(int'(level_out) == exp_lvl, req, int'(level_out), exp_lvl);
            chk(seg_upper == (keff >= t1c), {req, " seg"}, int'(seg_upper),
                int'(keff >= t1c));
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(level_out == 3'sd0, "R1 level", int'(level_out), 0);
        chk(seg_upper == 1'b0, "R1 seg", int'(seg_upper), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(level_out == 3'sd0, "R1 level after release", int'(level_out), 0);
    endtask

    task automatic t_bracket;
        run_period(150, 100, 7, 1, 2, P + 3, "R2 R3 mid pair");
        run_period(100, 100, 5, 1, 2, P + 3, "R2 exact level");
        run_period(-300, 100, 12, -3, -2, P + 3, "R2 bottom level exact");
        run_period(-1, 100, 3, -1, 0, P + 3, "R2 just below zero");
        run_period(299, 100, 10, 2, 3, P + 3, "R2 R10 top pair");
        run_period(0, 100, 1, 0, 1, P + 3, "R3 zero demand");
    endtask

    task automatic t_saturate;
        run_period(300, 100, 6, 3, 3, P + 3, "R4 at +3");
        run_period(1000, 100, 9, 3, 3, P + 3, "R4 beyond +3");
        run_period(-301, 100, 9, -3, -3, P + 3, "R5 below -3");
    endtask

    task automatic t_clamp;
        run_period(150, 100, -5, 1, 2, P + 3, "R6 negative duration");
        run_period(150, 100, 30, 1, 2, P + 3, "R6 long duration");
        run_period(-150, 100, P, -2, -1, P + 3, "R6 full period");
    endtask

    task automatic t_restart;
        run_period(150, 100, 8, 1, 2, 5, "R8 first part");
        run_period(-150, 100, 4, -2, -1, P + 3, "R8 restarted");
    endtask

    initial begin
        t_reset();
        t_bracket();
        t_saturate();
        t_clamp();
        t_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule